// File: doc/BRIEF.md
# Programmable Pseudorandom and Repeating Test Pattern Generator

This block is the transmit half of a bit error rate tester. On its own clock it produces a serial test stream with one bit per enabled bit time. The stream comes from one of two sources. The first is a pseudorandom sequence from a Fibonacci shift register, whose length (1 to 32 stages) and feedback taps are set by software. The second is a user word of 1 to 32 bits that is sent over and over. A transmit-disable input freezes the generator for as many cycles as it is held. This lets the stream follow gapped or fractional channel clocks without losing its place in the sequence.

Software writes five registers over a simple write-only register bus. Mode, length, taps and word are written into staging registers. They have no effect until a load command copies them into the active set and reseeds the shift register. Errors can be added to the stream for test purposes. A single-error command inverts exactly one later bit. A decade-rate setting inverts every 10^N-th transmitted bit, with N from 1 to 7.

The sequencing is a four-state machine:
- IDLE: the state after reset. Nothing is sent.
- LOAD: lasts one cycle and seeds the register.
- RUN: a bit is sent on every cycle.
- GAP: transmit-disable was high.

The transitions are:
- Any state goes to LOAD on a load command. This transition has priority.
- IDLE stays in IDLE.
- LOAD, RUN and GAP each go to GAP when transmit-disable is high, and to RUN when it is low.

Top module: `bert_tx_gen`

## Requirements
- R1: After reset, tx_bit and tx_bit_vld are 0, and no bit is sent, even with tx_dis low, until the first load command.
- R2: In pseudorandom mode (CFG bit 0 = 0), each sent bit is stage L-1 of the register. The register then shifts one place toward higher stages, and stage 0 takes the XOR of the stages selected by the TAPS mask. With maximal taps, lengths 6, 9 and 11 give periods of 63, 511 and 2047.
- R3: The length L is CFG[12:8]+1, so any value from 1 to 32 is valid. A 32-stage register works.
- R4: In repeating mode (CFG bit 0 = 1), the low L bits of WORD are sent from bit L-1 down to bit 0, and this repeats without end.
- R5: A clock edge with tx_dis high sends no bit. tx_bit_vld is 0 after that edge, and tx_bit holds its value. The sequence then resumes with no bit lost. An edge in RUN or GAP with tx_dis low sends one bit and sets tx_bit_vld.
- R6: Writing 1 to CMD bit 1 inverts exactly one bit: the next bit sent.
- R7: A value N = RATE[2:0] from 1 to 7 inverts every 10^N-th sent bit. N = 0 inserts no rate errors.
- R8: The rate counter counts only sent bits, not gapped cycles. A load command or a RATE write clears it.
- R9: In pseudorandom mode, an all-zero register (or an all-zero seed) is treated as the value 1, so the sequence cannot lock up.
- R10: Writes to CFG, TAPS and WORD do not change the stream until a load command (CMD bit 0). The load command reseeds the register with WORD masked to L bits. The first new bit appears on the second edge after the command edge.
- R11: The register addresses are CFG=0, TAPS=1, WORD=2, RATE=3 and CMD=4. Writes to addresses 5 to 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | W | Register write data |
| tx_dis | input | 1 | Transmit disable (gap) |
| tx_bit | output | 1 | Serial test bit |
| tx_bit_vld | output | 1 | A new bit was sent on the last edge |

## Verification
A corrupted shift-register stage or a wrong tap term shows up at tx_bit within L sent bits. After that, every bit drifts from the expected sequence, so a per-bit comparison over a few hundred bits detects it, and a period check detects a non-maximal loop. A wrong gap or enable state shows immediately on the next edge, either as tx_bit_vld set during a gap or as tx_bit changing while disabled. Counter faults in the error injector show as misplaced or missing inverted bits. These appear within 10^N sent bits, and 10^N is kept at 10 and 100 so they are seen quickly.

// File: rtl/bert_tx_pkg.sv
package bert_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2,
        ST_GAP  = 2'd3
    } tx_state_e;

    typedef enum logic {
        MODE_PRBS   = 1'b0,
        MODE_REPEAT = 1'b1
    } tx_mode_e;

    // register addresses
    localparam int unsigned A_CFG  = 0;
    localparam int unsigned A_TAPS = 1;
    localparam int unsigned A_WORD = 2;
    localparam int unsigned A_RATE = 3;
    localparam int unsigned A_CMD  = 4;

    // field positions
    localparam int unsigned CFG_MODE_BIT = 0;
    localparam int unsigned CFG_LEN_LSB  = 8;
    localparam int unsigned CMD_LOAD_BIT = 0;
    localparam int unsigned CMD_ERR_BIT  = 1;

    function automatic int unsigned pow10(input int unsigned n);
        int unsigned v;
        v = 1;
        for (int unsigned i = 0; i < n; i++) v = v * 10;
        return v;
    endfunction

endpackage

// File: rtl/bert_tx_regs.sv
module bert_tx_regs
    import bert_tx_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 3,
    parameter int LEN_W  = 5,
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output tx_mode_e          act_mode,
    output logic [LEN_W-1:0]  act_len_m1,
    output logic [W-1:0]      act_taps,
    output logic [W-1:0]      act_word,
    output logic [RATE_W-1:0] rate_exp,
    output logic              load_cmd,
    output logic              single_cmd,
    output logic              rate_wr
);

    logic sel_cfg, sel_taps, sel_word, sel_rate, sel_cmd;

    tx_mode_e         stg_mode;
    logic [LEN_W-1:0] stg_len_m1;
    logic [W-1:0]     stg_taps;
    logic [W-1:0]     stg_word;

    always_comb begin
        sel_cfg  = wr && (addr == ADDR_W'(A_CFG));
        sel_taps = wr && (addr == ADDR_W'(A_TAPS));
        sel_word = wr && (addr == ADDR_W'(A_WORD));
        sel_rate = wr && (addr == ADDR_W'(A_RATE));
        sel_cmd  = wr && (addr == ADDR_W'(A_CMD));
        load_cmd   = sel_cmd && wdata[CMD_LOAD_BIT];
        single_cmd = sel_cmd && wdata[CMD_ERR_BIT];
        rate_wr    = sel_rate;
    end

    // staging set: written freely, no effect on the stream
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_mode   <= MODE_PRBS;
            stg_len_m1 <= '1;
            stg_taps   <= '0;
            stg_word   <= '0;
        end else begin
            if (sel_cfg) begin
                stg_mode   <= tx_mode_e'(wdata[CFG_MODE_BIT]);
                stg_len_m1 <= wdata[CFG_LEN_LSB +: LEN_W];
            end
            if (sel_taps) stg_taps <= wdata;
            if (sel_word) stg_word <= wdata;
        end
    end

    // active set: copied on the load command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_mode   <= MODE_PRBS;
            act_len_m1 <= '1;
            act_taps   <= '0;
            act_word   <= '0;
        end else if (load_cmd) begin
            act_mode   <= stg_mode;
            act_len_m1 <= stg_len_m1;
            act_taps   <= stg_taps;
            act_word   <= stg_word;
        end
    end

    // the rate takes effect at once
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rate_exp <= '0;
        else if (sel_rate) rate_exp <= wdata[RATE_W-1:0];
    end

endmodule

// File: rtl/bert_tx_fsm.sv
module bert_tx_fsm
    import bert_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_cmd,
    input  logic      tx_dis,
    output tx_state_e state,
    output logic      seed_en,
    output logic      adv
);

    tx_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = ST_IDLE;
            ST_LOAD: state_d = tx_dis ? ST_GAP : ST_RUN;
            ST_RUN:  state_d = tx_dis ? ST_GAP : ST_RUN;
            ST_GAP:  state_d = tx_dis ? ST_GAP : ST_RUN;
            default: state_d = ST_IDLE;
        endcase
        if (load_cmd) state_d = ST_LOAD;
    end

    always_comb begin
        seed_en = 1'b0;
        adv     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOAD: seed_en = 1'b1;
            ST_RUN:  adv = !tx_dis;
            ST_GAP:  adv = !tx_dis;
            default: ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/bert_tx_pattern.sv
module bert_tx_pattern
    import bert_tx_pkg::*;
#(
    parameter int W     = 32,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seed_en,
    input  logic             adv,
    input  tx_mode_e         mode,
    input  logic [LEN_W-1:0] len_m1,
    input  logic [W-1:0]     taps,
    input  logic [W-1:0]     word,
    output logic             cur_bit
);

    localparam logic [LEN_W:0] TOP_IDX = (LEN_W+1)'(W - 1);

    logic [W-1:0] sr_q;
    logic [W-1:0] len_mask, raw, eff, nxt, seed_raw, seed;
    logic         fb;

    always_comb begin
        len_mask = {W{1'b1}} >> (TOP_IDX - {1'b0, len_m1});
        raw      = sr_q & len_mask;
        // zero state in pseudorandom mode is replaced by 1
        eff      = (mode == MODE_PRBS && raw == '0) ? W'(1) : raw;
        cur_bit  = eff[len_m1];
        fb       = (mode == MODE_PRBS) ? ^(eff & taps) : cur_bit;
        nxt      = ((eff << 1) | W'(fb)) & len_mask;
        seed_raw = word & len_mask;
        seed     = (mode == MODE_PRBS && seed_raw == '0) ? W'(1) : seed_raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sr_q <= '0;
        else if (seed_en) sr_q <= seed;
        else if (adv)     sr_q <= nxt;
    end

endmodule

// File: rtl/bert_tx_errins.sv
module bert_tx_errins
    import bert_tx_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              clr,
    input  logic              single_cmd,
    input  logic [RATE_W-1:0] rate_exp,
    output logic              inv,
    output logic              single_pending
);

    localparam int N_RATES = 1 << RATE_W;

    logic [CNT_W-1:0] lim_m1 [N_RATES];
    logic [CNT_W-1:0] cnt_q;
    logic             rate_hit;
    logic             pend_q;

    for (genvar g = 0; g < N_RATES; g++) begin : g_lim
        assign lim_m1[g] = CNT_W'(pow10(g) - 1);
    end

    always_comb begin
        rate_hit = (rate_exp != '0) && (cnt_q == lim_m1[rate_exp]);
        inv      = pend_q | rate_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (clr)                      cnt_q <= '0;
        else if (adv && rate_exp != '0)    cnt_q <= rate_hit ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (single_cmd) pend_q <= 1'b1;
        else if (adv)        pend_q <= 1'b0;
    end

    assign single_pending = pend_q;

endmodule

// File: rtl/bert_tx_gen.sv
module bert_tx_gen
    import bert_tx_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    input  logic              tx_dis,
    output logic              tx_bit,
    output logic              tx_bit_vld
);

    localparam int LEN_W  = $clog2(W);
    localparam int RATE_W = 3;

    tx_mode_e          act_mode;
    logic [LEN_W-1:0]  act_len_m1;
    logic [W-1:0]      act_taps, act_word;
    logic [RATE_W-1:0] rate_exp;
    logic              load_cmd, single_cmd, rate_wr;
    tx_state_e         fsm_state;
    logic              seed_en, adv;
    logic              cur_bit, inv, single_pending;

    bert_tx_regs #(.W(W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .RATE_W(RATE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .act_mode   (act_mode),
        .act_len_m1 (act_len_m1),
        .act_taps   (act_taps),
        .act_word   (act_word),
        .rate_exp   (rate_exp),
        .load_cmd   (load_cmd),
        .single_cmd (single_cmd),
        .rate_wr    (rate_wr)
    );

    bert_tx_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_cmd (load_cmd),
        .tx_dis   (tx_dis),
        .state    (fsm_state),
        .seed_en  (seed_en),
        .adv      (adv)
    );

    bert_tx_pattern #(.W(W), .LEN_W(LEN_W)) u_pat (
        .clk     (clk),
        .rst_n   (rst_n),
        .seed_en (seed_en),
        .adv     (adv),
        .mode    (act_mode),
        .len_m1  (act_len_m1),
        .taps    (act_taps),
        .word    (act_word),
        .cur_bit (cur_bit)
    );

    bert_tx_errins #(.CNT_W(CNT_W), .RATE_W(RATE_W)) u_err (
        .clk            (clk),
        .rst_n          (rst_n),
        .adv            (adv),
        .clr            (seed_en | rate_wr),
        .single_cmd     (single_cmd),
        .rate_exp       (rate_exp),
        .inv            (inv),
        .single_pending (single_pending)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_bit     <= 1'b0;
            tx_bit_vld <= 1'b0;
        end else begin
            tx_bit_vld <= adv;
            if (adv) tx_bit <= cur_bit ^ inv;
        end
    end

endmodule

// File: rtl/bert_tx_gen_chk.sv
module bert_tx_gen_chk
    import bert_tx_pkg::*;
#(
    parameter int RATE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_dis,
    input logic              tx_bit,
    input logic              tx_bit_vld,
    input tx_state_e         state,
    input logic              load_cmd,
    input logic              single_cmd,
    input logic              single_pending,
    input logic              adv,
    input logic              inv,
    input logic [RATE_W-1:0] rate_exp
);

    // R1: nothing is sent while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> !tx_bit_vld);

    // R5: a gapped edge sends nothing and holds the bit
    p_gap_novld_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dis |=> !tx_bit_vld);

    p_gap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dis |=> $stable(tx_bit));

    // R10: the load state lasts a single cycle
    p_load_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && !load_cmd) |=> (state == ST_RUN || state == ST_GAP));

    // R7: no inversion with rate off and nothing pending
    p_rate_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_exp == '0 && !single_pending) |-> !inv);

    // R6: a pending single error is consumed by one sent bit
    p_single_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (single_pending && adv && !single_cmd) |=> !single_pending);

endmodule

bind bert_tx_gen bert_tx_gen_chk #(.RATE_W(RATE_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tx_dis         (tx_dis),
    .tx_bit         (tx_bit),
    .tx_bit_vld     (tx_bit_vld),
    .state          (fsm_state),
    .load_cmd       (load_cmd),
    .single_cmd     (single_cmd),
    .single_pending (single_pending),
    .adv            (adv),
    .inv            (inv),
    .rate_exp       (rate_exp)
);

// File: tb/bert_tx_gen_test.sv
`timescale 1ns/1ps
module bert_tx_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        tx_dis = 1'b1;
    logic        tx_bit, tx_bit_vld;

    always #10 clk = ~clk;

    bert_tx_gen uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .tx_dis(tx_dis), .tx_bit(tx_bit), .tx_bit_vld(tx_bit_vld)
    );

    int n_chk = 0, n_fail = 0;

    // staged and active model state
    bit        s_mode;  int s_len;  bit [31:0] s_taps, s_word;
    bit        m_mode;  int m_len;  bit [31:0] m_taps, m_sr;
    int        m_k, m_rate;  bit m_single;

    bit cb [4096];
    int r_errs, r_raw, r_gap, r_ones;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit [31:0] lmask(input int L);
        if (L >= 32) return 32'hFFFF_FFFF;
        return (32'h1 << L) - 32'h1;
    endfunction

    function automatic int pw10(input int n);
        int v = 1;
        for (int i = 0; i < n; i++) v = v * 10;
        return v;
    endfunction

    task automatic model_next(output bit eb, output bit pb);
        bit [31:0] mk, eff;
        bit fb, inj;
        mk  = lmask(m_len);
        eff = m_sr & mk;
        if (!m_mode && eff == 0) eff = 1;
        pb = eff[m_len-1];
        fb = m_mode ? pb : ^(eff & m_taps);
        m_sr = ((eff << 1) | {31'b0, fb}) & mk;
        m_k++;
        inj = m_single;
        m_single = 0;
        if (m_rate != 0 && (m_k % pw10(m_rate)) == 0) inj = 1;
        eb = pb ^ inj;
    endtask

    task automatic bus_wr(input int a, input bit [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_cfg(input bit mode, input int len, input bit [31:0] taps, input bit [31:0] word);
        bit [4:0] l5;
        l5 = 5'(len - 1);
        bus_wr(0, {19'b0, l5, 7'b0, mode});
        bus_wr(1, taps);
        bus_wr(2, word);
        s_mode = mode; s_len = len; s_taps = taps; s_word = word;
    endtask

    task automatic do_load();
        bit [31:0] sd;
        bus_wr(4, 32'h1);
        m_mode = s_mode; m_len = s_len; m_taps = s_taps; m_k = 0;
        sd = s_word & lmask(s_len);
        if (!m_mode && sd == 0) sd = 1;
        m_sr = sd;
        @(negedge clk);
        check(tx_bit_vld == 1'b0, "R10", "no bit during seeding", tx_bit_vld, 0);
    endtask

    task automatic run(input int nbits, input int gap_pct);
        bit eb, pb, last, prev_dis;
        int got = 0;
        r_errs = 0; r_raw = 0; r_gap = 0; r_ones = 0;
        last = tx_bit; prev_dis = tx_dis;
        while (1) begin
            @(negedge clk);
            if (tx_bit_vld) begin
                model_next(eb, pb);
                if (tx_bit !== eb) r_errs++;
                if (tx_bit !== pb) r_raw++;
                if (got < 4096) cb[got] = tx_bit;
                r_ones += int'(tx_bit);
                got++;
                last = tx_bit;
                if (prev_dis) r_gap++;
            end else begin
                if (tx_bit !== last) r_gap++;
                if (!prev_dis) r_gap++;
            end
            if (got >= nbits) begin
                tx_dis = 1'b1;
                break;
            end
            tx_dis = (($urandom % 100) < gap_pct);
            prev_dis = tx_dis;
        end
    endtask

    function automatic int lag_diff(input int p, input int n);
        int d = 0;
        for (int i = 0; i < n; i++) if (cb[i] != cb[i+p]) d++;
        return d;
    endfunction

    task automatic period_check(input string req, input int per, input int l1, input int l2, input int l3);
        int bad;
        check(lag_diff(per, per) == 0, req, "sequence repeats at its period", lag_diff(per, per), 0);
        bad = 0;
        if (lag_diff(l1, per) == 0) bad++;
        if (lag_diff(l2, per) == 0) bad++;
        if (lag_diff(l3, per) == 0) bad++;
        check(bad == 0, req, "no shorter period", bad, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int unsigned sd;
        int idle_bad;
        bit eb, pb;
        sd = $urandom(32'd20240611);

        repeat (3) @(negedge clk);
        check(tx_bit == 1'b0, "R1", "tx_bit in reset", tx_bit, 0);
        check(tx_bit_vld == 1'b0, "R1", "tx_bit_vld in reset", tx_bit_vld, 0);
        rst_n = 1'b1;
        tx_dis = 1'b0;
        idle_bad = 0;
        repeat (10) begin
            @(negedge clk);
            if (tx_bit_vld) idle_bad++;
        end
        check(idle_bad == 0, "R1", "no bits before first load", idle_bad, 0);

        // R2 / R10: length 6, first bit two edges after load
        set_cfg(1'b0, 6, 32'h30, 32'h3F);
        do_load();
        @(negedge clk);
        model_next(eb, pb);
        check(tx_bit_vld == 1'b1, "R10", "first bit valid on second edge", tx_bit_vld, 1);
        check(tx_bit == eb, "R10", "first bit value", tx_bit, eb);
        tx_dis = 1'b1;
        run(126, 25);
        check(r_errs == 0, "R2", "length 6 sequence", r_errs, 0);
        check(r_gap == 0, "R5", "gap behaviour length 6", r_gap, 0);
        check(r_ones == 64, "R2", "ones in two periods of 63", r_ones, 64);
        period_check("R2", 63, 21, 9, 7);

        // R2: length 9 and 11
        set_cfg(1'b0, 9, 32'h110, 32'h1);
        do_load();
        run(1022, 10);
        check(r_errs == 0, "R2", "length 9 sequence", r_errs, 0);
        period_check("R2", 511, 73, 7, 1);
        set_cfg(1'b0, 11, 32'h500, 32'h5A5);
        do_load();
        run(4094, 5);
        check(r_errs == 0, "R2", "length 11 sequence", r_errs, 0);
        period_check("R2", 2047, 89, 23, 1);

        // R3: 32 stages
        set_cfg(1'b0, 32, 32'h8020_0003, 32'hACE1_2345);
        do_load();
        run(400, 30);
        check(r_errs == 0, "R3", "32-stage sequence", r_errs, 0);
        check(r_gap == 0, "R5", "gap behaviour 32 stages", r_gap, 0);

        // R4: repeating word 10110, length 5
        begin
            int bad = 0;
            set_cfg(1'b1, 5, 32'h0, 32'h16);
            do_load();
            run(20, 20);
            for (int i = 0; i < 20; i++) begin
                bit [4:0] w = 5'h16;
                if (cb[i] != w[4 - (i % 5)]) bad++;
            end
            check(bad == 0, "R4", "word 10110 sent MSB first", bad, 0);
        end
        set_cfg(1'b1, 1, 32'h0, 32'h1);
        do_load();
        run(12, 30);
        check(r_ones == 12, "R3", "length 1 word of 1", r_ones, 12);

        for (int it = 0; it < 6; it++) begin
            int len;
            bit [31:0] w;
            len = 1 + int'($urandom % 32);
            w = $urandom;
            set_cfg(1'b1, len, 32'h0, w);
            do_load();
            run(3 * len + 7, int'($urandom % 60));
            check(r_errs == 0, "R4", "random repeating word", r_errs, 0);
            check(r_gap == 0, "R5", "random gaps", r_gap, 0);
        end

        // R6: single error
        set_cfg(1'b0, 9, 32'h110, 32'h1F);
        do_load();
        run(30, 20);
        bus_wr(4, 32'h2);
        m_single = 1;
        run(60, 20);
        check(r_errs == 0, "R6", "inverted bit is the next one", r_errs, 0);
        check(r_raw == 1, "R6", "exactly one inverted bit", r_raw, 1);

        // R7 / R8: decade rate
        bus_wr(3, 32'h1); m_rate = 1; m_k = 0;
        run(200, 40);
        check(r_errs == 0, "R8", "rate 10 positions with gaps", r_errs, 0);
        check(r_raw == 20, "R7", "errors at one in 10", r_raw, 20);
        bus_wr(3, 32'h2); m_rate = 2; m_k = 0;
        run(1000, 10);
        check(r_raw == 10, "R7", "errors at one in 100", r_raw, 10);
        run(50, 10);
        bus_wr(3, 32'h2); m_k = 0;
        run(150, 10);
        check(r_raw == 1, "R8", "rate write clears counter", r_raw, 1);
        bus_wr(3, 32'h1); m_rate = 1; m_k = 0;
        run(4, 0);
        do_load();
        run(15, 20);
        check(r_errs == 0, "R8", "load clears counter", r_errs, 0);
        bus_wr(3, 32'h0); m_rate = 0;
        run(300, 10);
        check(r_raw == 0, "R7", "rate off inserts nothing", r_raw, 0);

        // R9: lock-up avoidance
        set_cfg(1'b0, 4, 32'h0, 32'h1);
        do_load();
        run(12, 0);
        check(r_errs == 0 && r_ones == 3, "R9", "zero state reseeded (ones)", r_ones, 3);
        set_cfg(1'b0, 9, 32'h110, 32'h0);
        do_load();
        run(40, 15);
        check(r_errs == 0 && r_ones > 0, "R9", "zero seed replaced (ones)", r_ones, 1);

        // R10 / R11: staging and ignored addresses
        set_cfg(1'b1, 8, 32'h0, 32'hA5);
        do_load();
        run(16, 20);
        set_cfg(1'b0, 6, 32'h30, 32'h3F);
        bus_wr(6, 32'h1);
        bus_wr(7, 32'h2);
        bus_wr(5, 32'h3);
        run(40, 20);
        check(r_errs == 0, "R10", "staged writes leave stream unchanged", r_errs, 0);
        check(r_raw == 0, "R11", "writes to addresses 5..7 ignored", r_raw, 0);
        do_load();
        run(63, 20);
        check(r_errs == 0, "R10", "load applies staged setup", r_errs, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule